// File: doc/BRIEF.md
# Staged Watchdog

A watchdog that escalates through five stages toward a system reset. It listens to sixteen timer expiry pulses, counts only the one picked by its configuration, and each time that timer has expired the configured number of times it moves up one stage. Stage one raises a local interrupt, which software treats as a prompt to service the watchdog. Stage two raises a fast local interrupt and stage three a remote interrupt. Stage four requests a debug reset and stage five a power-on reset. Each output has its own enable bit. With a period of one expiration, the power-on reset request follows the fifth expiration after start.

Software writes the configuration while the block is stopped and then issues a start command. To service the watchdog it writes a key value to the unlock register, then a disable command, then a start command. A disable that does not directly follow the key is ignored, so a runaway write cannot stop the watchdog. While the watchdog runs, its configuration cannot be changed.

Top module: `staged_watchdog`

## Requirements
- R1: After reset all five outputs are low and the configuration reads back as zero.
- R2: While stopped, a write at offset 0x0 stores the configuration, which reads back at offset 0x0. Bits 3:0 select the source timer, bits 11:4 give the expirations per stage, and bits 12, 13, 14, 15 and 16 enable the local interrupt, fast interrupt, remote interrupt, debug reset and power-on reset.
- R3: While running, writes to the configuration have no effect. After an accepted disable they take effect again.
- R4: Writing bit 0 at offset 0x8 starts the watchdog from stage 0 with a zero expiration count. Only pulses on the selected source timer are counted.
- R5: The stage rises by one on the expiration that completes the configured period. A period of 0 acts as 1.
- R6: The local, fast and remote interrupts are high while running at or beyond stages 1, 2 and 3, each only when enabled. They drop on a start or an accepted disable.
- R7: The debug reset request rises when stage 4 is entered and the power-on reset request when stage 5 is entered, each only when enabled. Both then stay high until the block is reset.
- R8: Bit 1 at offset 0x8 disables the watchdog only if the last write at offset 0xC was 0x0000C45A and no command write has come since. Any command write uses up the unlock, and any other value written at 0xC clears it.
- R9: The stage stays at 5. Further expirations change nothing.
- R10: A start while running restarts the sequence from stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 4 | Read byte offset |
| bus_rdata | output | 32 | Read data (configuration at 0x0, zero elsewhere) |
| tick_in | input | 16 | One-cycle expiry pulses from the timers |
| irq_local | output | 1 | Stage 1 keep-alive interrupt |
| irq_fast | output | 1 | Stage 2 fast interrupt |
| irq_remote | output | 1 | Stage 3 remote interrupt |
| dbg_rst_req | output | 1 | Sticky stage 4 debug reset request |
| por_rst_req | output | 1 | Sticky stage 5 power-on reset request |

## Verification
On every cycle the assertions check several properties. The stage never passes 5. It moves by at most one step between command writes. The configuration holds while the watchdog runs. A command write without an unlock never stops a running watchdog. The interrupts appear only while running, and the reset requests are sticky and rise only at their stage. Only the bench scenarios show the exact expiration on which each output rises for a given period. They also show that the source selection ignores other timers, that an unlock is used up by an intervening start and cleared by a wrong value, and that a restart gives a full new sequence.

// File: rtl/staged_watchdog.sv
module staged_watchdog #(
  parameter logic [31:0] KEY = 32'h0000_C45A,
  parameter int          AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [31:0]   bus_rdata,
  input  logic [15:0]   tick_in,
  output logic          irq_local,
  output logic          irq_fast,
  output logic          irq_remote,
  output logic          dbg_rst_req,
  output logic          por_rst_req
);
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_CMD = AW'(8);
  localparam logic [AW-1:0] A_KEY = AW'(12);
  localparam logic [2:0]    LAST  = 3'd5;

  logic [16:0] cfg_q;
  logic        run_q, armed_q, dbg_q, por_q;
  logic [7:0]  exp_q;
  logic [2:0]  stage_q;

  wire cfg_we = bus_we && bus_addr == A_CFG;
  wire cmd_we = bus_we && bus_addr == A_CMD;
  wire key_we = bus_we && bus_addr == A_KEY;

  wire [7:0] limit   = (cfg_q[11:4] == 8'd0) ? 8'd1 : cfg_q[11:4];
  wire       tick    = tick_in[cfg_q[3:0]];
  wire       do_stop = cmd_we && bus_wdata[1] && armed_q;
  wire       do_go   = cmd_we && bus_wdata[0] && !do_stop;
  wire       count   = run_q && tick && stage_q < LAST;
  wire       step    = count && ({1'b0, exp_q} + 9'd1 == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      exp_q   <= '0;
      stage_q <= '0;
    end else if (do_stop) begin
      run_q   <= 1'b0;
      exp_q   <= '0;
      stage_q <= '0;
    end else if (do_go) begin
      run_q   <= 1'b1;
      exp_q   <= '0;
      stage_q <= '0;
    end else if (step) begin
      exp_q   <= '0;
      stage_q <= stage_q + 3'd1;
    end else if (count) begin
      exp_q   <= exp_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
      dbg_q   <= 1'b0;
      por_q   <= 1'b0;
    end else begin
      if (cfg_we && !run_q) cfg_q <= bus_wdata[16:0];
      if (key_we)           armed_q <= (bus_wdata == KEY);
      else if (cmd_we)      armed_q <= 1'b0;
      if (step && stage_q == 3'd3 && cfg_q[15]) dbg_q <= 1'b1;
      if (step && stage_q == 3'd4 && cfg_q[16]) por_q <= 1'b1;
    end
  end

  assign irq_local   = run_q && stage_q >= 3'd1 && cfg_q[12];
  assign irq_fast    = run_q && stage_q >= 3'd2 && cfg_q[13];
  assign irq_remote  = run_q && stage_q >= 3'd3 && cfg_q[14];
  assign dbg_rst_req = dbg_q;
  assign por_rst_req = por_q;
  assign bus_rdata   = (bus_raddr == A_CFG) ? {15'd0, cfg_q} : 32'd0;

  // R9
  stage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q <= LAST);
  // R5
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> (stage_q == $past(stage_q) || stage_q == $past(stage_q) + 3'd1));
  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(cfg_q));
  // R8
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !armed_q && run_q) |=> run_q);
  // R6
  irq_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_local || irq_fast || irq_remote) |-> run_q);
  // R7
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_rst_req |=> por_rst_req);
  // R7
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rst_req |=> dbg_rst_req);
  // R7
  por_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_rst_req) |-> stage_q == LAST);
endmodule

// File: tb/sim_staged_watchdog.sv
module sim_staged_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tick_in = '0;
  logic        irq_local, irq_fast, irq_remote, dbg_rst_req, por_rst_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  staged_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .irq_local(irq_local), .irq_fast(irq_fast),
    .irq_remote(irq_remote), .dbg_rst_req(dbg_rst_req), .por_rst_req(por_rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; tick_in = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      tick_in = 16'(1) << idx;
      @(negedge clk);
      tick_in = '0;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] rd_cfg();
    return bus_rdata;
  endfunction

  task automatic t_reset();
    do_reset();
    bus_raddr = 4'h0; #1;
    check("R1 cfg", bus_rdata, 32'h0);
    check("R1 outs", {irq_local, irq_fast, irq_remote, dbg_rst_req, por_rst_req}, 32'h0);
  endtask

  task automatic t_full_sequence();
    do_reset();
    wr(4'h0, 32'h0001_F015);
    bus_raddr = 4'h0; #1;
    check("R2 readback", bus_rdata, 32'h0001_F015);
    wr(4'h8, 32'h1);
    pulse(3, 2);
    check("R4 other source ignored", irq_local, 0);
    pulse(5, 1);
    check("R6 local at stage1", {irq_local, irq_fast}, 32'h2);
    pulse(5, 1);
    check("R6 fast at stage2", {irq_fast, irq_remote}, 32'h2);
    pulse(5, 1);
    check("R6 remote at stage3", {irq_remote, dbg_rst_req}, 32'h2);
    pulse(5, 1);
    check("R7 debug at stage4", {dbg_rst_req, por_rst_req}, 32'h2);
    pulse(5, 1);
    check("R7 por at fifth expiry", por_rst_req, 1);
    pulse(5, 3);
    check("R9 saturated", {irq_local, irq_fast, irq_remote, dbg_rst_req, por_rst_req}, 32'h1F);
    wr(4'h0, 32'h0);
    #1;
    check("R3 cfg locked", bus_rdata, 32'h0001_F015);
    wr(4'h8, 32'h2);
    check("R8 disable without key ignored", irq_local, 1);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h2);
    check("R8 keyed disable stops", {irq_local, irq_fast, irq_remote}, 32'h0);
    check("R7 resets sticky after disable", {dbg_rst_req, por_rst_req}, 32'h3);
    wr(4'h0, 32'h0000_1010);
    #1;
    check("R3 cfg writable after disable", bus_rdata, 32'h0000_1010);
  endtask

  task automatic t_period_restart();
    do_reset();
    wr(4'h0, 32'h0000_1032);
    wr(4'h8, 32'h1);
    pulse(2, 2);
    check("R5 below period", irq_local, 0);
    pulse(2, 1);
    check("R5 period reached", irq_local, 1);
    pulse(2, 3);
    check("R6 fast disabled", {irq_fast, irq_local}, 32'h1);
    wr(4'h8, 32'h1);
    check("R10 restart clears", irq_local, 0);
    pulse(2, 2);
    check("R10 count restarted", irq_local, 0);
    pulse(2, 1);
    check("R10 stage1 again", irq_local, 1);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h1);
    wr(4'h8, 32'h2);
    check("R8 key used by start", irq_local, 0);
    pulse(2, 3);
    check("R8 still running", irq_local, 1);
    wr(4'hC, 32'h0000_1234);
    wr(4'h8, 32'h2);
    check("R8 wrong key", irq_local, 1);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h2);
    check("R8 right key", irq_local, 0);
    pulse(2, 6);
    check("R4 stopped ignores ticks", irq_local, 0);
  endtask

  task automatic t_period_zero();
    do_reset();
    wr(4'h0, 32'h0000_1000);
    wr(4'h8, 32'h1);
    check("R4 start at stage0", irq_local, 0);
    pulse(0, 1);
    check("R5 period zero acts as one", irq_local, 1);
  endtask

  initial begin
    t_reset();
    t_full_sequence();
    t_period_restart();
    t_period_zero();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule